// File: doc/BRIEF.md
# Multi-Slot NAND ECC Accumulation Sequencer

This block sits beside a NAND data path. It builds a check value over successive stretches of page data and stores each finished value in a bank of nine result slots. It watches a transfer stream made of a valid strobe, a chip-select index and a 16-bit data word. Only transfers to the chip-select it has been told to watch are counted. Each counted transfer is one unit. In byte mode the unit is the low eight bits of the data word. In word mode it is the full sixteen bits.

Every slot closes after a unit count that it takes from one of two programmable sizes, so the main page area and a short spare area can share one run. When a slot closes, the running value is stored in the slot the pointer names, and the pointer steps to the next slot. After the ninth slot is filled, the pointer parks one past the end and the block switches itself off. Software reads the pointer to learn how many results are valid. Result j is valid once the pointer reads j+1.

The check value is kept simple and is formed from two fields. The low half of a result is the XOR of all units in the slot. The high half is the number of those units that have odd parity. A register port sets up the run. While a run is active, that port refuses every change to the setup except switching the run off.

Top module: `nand_ecc_seq`

## Requirements
- R1: After reset the pointer reads 1, enable is 0, `busy` and `done` are 0, all nine results read 0, and both sizes read 2.
- R2: While enabled with the pointer in 1..9, each cycle with `xfer_valid` high and `xfer_cs` equal to the chip-select field adds one unit. A stored result is {count of odd-parity units [31:16], XOR of units [15:0]}. In byte mode (width bit 0) a unit is `xfer_data[7:0]` with the upper byte taken as zero. In word mode (width bit 1) it is all 16 bits.
- R3: Slot j closes after size0 units if select bit j-1 is 0, and after size1 units if that bit is 1. Legal sizes are even values from 2 to 512.
- R4: When a slot closes, the result is written into the slot the pointer names and the pointer increments by one. The running XOR, the odd count and the unit counter then restart from zero.
- R5: When slot 9 closes, the pointer stops at 10 and hardware clears enable. Later transfers change no result.
- R6: `done` is high for exactly one cycle, in the cycle after the clock edge that stores a result. `busy` is high from the write that sets enable until enable drops.
- R7: Transfers to any other chip-select, and transfers made while enable is 0, change neither the running value nor the unit counter.
- R8: Writing 1 to the clear bit while idle zeros all nine results, the running value and the unit counter. The clear bit always reads 0.
- R9: While busy, writes to the size and select registers are ignored. A control write while busy can only drop enable: the pointer, width and chip-select fields keep their values.
- R10: Register map (`reg_rdata` follows `reg_addr` in the same cycle). Address 0 is control: bit 0 enable, bit 1 clear, bits 7:4 pointer, bit 8 width, bits 11:9 chip-select. Address 1 holds size0 in [9:0] and size1 in [25:16]. Address 2 holds the select bits in [8:0], with bit j-1 for slot j. Address 2+j holds the result of slot j.
- R11: A pointer value written while idle picks the first slot the run fills. Slots before it stay untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| xfer_valid | input | 1 | A data transfer takes place this cycle |
| xfer_cs | input | 3 | Chip-select index of the transfer |
| xfer_data | input | 16 | Transfer data word |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address, used for both writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| busy | output | 1 | A run is armed or in progress |
| done | output | 1 | One-cycle pulse after each result is stored |

## Verification
The bench builds the block with its defaults: nine slots, 10-bit size fields, a 3-bit chip-select and 16-bit data. This makes the park value of 10 and the largest legal size of 512 reachable in a short run. A vector table runs complete sequences that differ in width mode, watched chip-select, start slot and mix of select bits. Foreign-select transfers are mixed into each sequence. Directed steps then cover frozen-state transfers, clear, writes refused while busy, and a run paused and resumed mid-slot.

// File: rtl/ecc_seq_pkg.sv
package ecc_seq_pkg;
  localparam int unsigned REG_W   = 32;
  // register addresses
  localparam int unsigned A_CTRL  = 0;
  localparam int unsigned A_SIZE  = 1;
  localparam int unsigned A_SEL   = 2;
  localparam int unsigned A_RES0  = 3;
  // control field positions
  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_CLR   = 1;
  localparam int unsigned B_PTR   = 4;
  localparam int unsigned B_WIDE  = 8;
  localparam int unsigned B_CS    = 9;
  // size register: second size starts here
  localparam int unsigned B_SIZE1 = 16;
endpackage

// File: rtl/ecc_cfg_regs.sv
module ecc_cfg_regs
  import ecc_seq_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 9,
  parameter int unsigned SIZE_W    = 10,
  parameter int unsigned CS_W      = 3,
  parameter int unsigned PTR_W     = 4,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [REG_W-1:0]     wr_data,
  input  logic                 slot_done,
  output logic                 en,
  output logic [PTR_W-1:0]     ptr,
  output logic                 wide,
  output logic [CS_W-1:0]      cs,
  output logic [SIZE_W-1:0]    size0,
  output logic [SIZE_W-1:0]    size1,
  output logic [NUM_SLOTS-1:0] sel,
  output logic                 clr
);
  logic                 en_q, en_d;
  logic [PTR_W-1:0]     ptr_q, ptr_d;
  logic                 wide_q;
  logic [CS_W-1:0]      cs_q;
  logic [SIZE_W-1:0]    size0_q, size1_q;
  logic [NUM_SLOTS-1:0] sel_q;
  logic                 idle, wr_ctrl, mode_ld, size_ld, sel_ld;
  logic                 unused_wbits;

  assign unused_wbits = ^wr_data;
  assign idle    = !en_q;
  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  assign mode_ld = wr_ctrl && idle;
  assign size_ld = wr_en && (wr_addr == ADDR_W'(A_SIZE)) && idle;
  assign sel_ld  = wr_en && (wr_addr == ADDR_W'(A_SEL)) && idle;
  assign clr     = mode_ld && wr_data[B_CLR];

  always_comb begin
    en_d  = en_q;
    ptr_d = ptr_q;
    if (slot_done) begin
      ptr_d = ptr_q + 1'b1;
      if (ptr_q == PTR_W'(NUM_SLOTS)) en_d = 1'b0;
    end
    if (wr_ctrl) begin
      if (idle) begin
        en_d  = wr_data[B_EN];
        ptr_d = wr_data[B_PTR +: PTR_W];
      end else begin
        en_d  = en_d & wr_data[B_EN];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      ptr_q   <= PTR_W'(1);
      wide_q  <= 1'b0;
      cs_q    <= '0;
      size0_q <= SIZE_W'(2);
      size1_q <= SIZE_W'(2);
      sel_q   <= '0;
    end else begin
      en_q  <= en_d;
      ptr_q <= ptr_d;
      if (mode_ld) begin
        wide_q <= wr_data[B_WIDE];
        cs_q   <= wr_data[B_CS +: CS_W];
      end
      if (size_ld) begin
        size0_q <= wr_data[SIZE_W-1:0];
        size1_q <= wr_data[B_SIZE1 +: SIZE_W];
      end
      if (sel_ld) sel_q <= wr_data[NUM_SLOTS-1:0];
    end
  end

  assign en    = en_q;
  assign ptr   = ptr_q;
  assign wide  = wide_q;
  assign cs    = cs_q;
  assign size0 = size0_q;
  assign size1 = size1_q;
  assign sel   = sel_q;
endmodule

// File: rtl/ecc_accum.sv
module ecc_accum #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SIZE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic                wide,
  input  logic [DATA_W-1:0]   data,
  input  logic [SIZE_W-1:0]   limit,
  input  logic                clr,
  output logic                close,
  output logic [2*DATA_W-1:0] res_next
);
  localparam int unsigned BYTE_W = 8;

  logic [DATA_W-1:0] mask, unit;
  logic [DATA_W-1:0] xsum_q, xsum_n, xsum_d;
  logic [DATA_W-1:0] odd_q, odd_n, odd_d;
  logic [SIZE_W-1:0] cnt_q, cnt_n, cnt_d;
  logic              ld;

  assign mask   = wide ? {DATA_W{1'b1}} : {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
  assign unit   = data & mask;
  assign xsum_n = xsum_q ^ unit;
  assign odd_n  = odd_q + DATA_W'(^unit);
  assign cnt_n  = cnt_q + 1'b1;
  assign close  = take && (cnt_n == limit);
  assign res_next = {odd_n, xsum_n};
  assign ld     = clr || take;

  always_comb begin
    xsum_d = xsum_n;
    odd_d  = odd_n;
    cnt_d  = cnt_n;
    if (clr || close) begin
      xsum_d = '0;
      odd_d  = '0;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xsum_q <= '0;
      odd_q  <= '0;
      cnt_q  <= '0;
    end else if (ld) begin
      xsum_q <= xsum_d;
      odd_q  <= odd_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/ecc_result_bank.sv
module ecc_result_bank #(
  parameter int unsigned NUM_SLOTS = 9,
  parameter int unsigned RES_W     = 32,
  parameter int unsigned PTR_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       store,
  input  logic [PTR_W-1:0]           ptr,
  input  logic [RES_W-1:0]           wdata,
  input  logic                       clr,
  output logic [NUM_SLOTS*RES_W-1:0] res_flat
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic             hit;
    logic [RES_W-1:0] val_q;
    assign hit = store && (ptr == PTR_W'(g + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= '0;
      else if (clr) val_q <= '0;
      else if (hit) val_q <= wdata;
    end
    assign res_flat[g*RES_W +: RES_W] = val_q;
  end
endmodule

// File: rtl/nand_ecc_seq.sv
module nand_ecc_seq
  import ecc_seq_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 9,
  parameter int unsigned SIZE_W    = 10,
  parameter int unsigned CS_W      = 3,
  parameter int unsigned DATA_W    = 16,
  localparam int unsigned PTR_W    = $clog2(NUM_SLOTS + 2),
  localparam int unsigned ADDR_W   = $clog2(NUM_SLOTS + A_RES0)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_valid,
  input  logic [CS_W-1:0]   xfer_cs,
  input  logic [DATA_W-1:0] xfer_data,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              busy,
  output logic              done
);
  localparam int unsigned RES_W = 2 * DATA_W;

  logic [1:0]               rst_sync;
  logic                     rst_core_n;
  logic                     en_w, wide_w, clr_w, take_w, close_w, adv_w, in_range;
  logic [PTR_W-1:0]         ptr_w;
  logic [CS_W-1:0]          cs_w;
  logic [SIZE_W-1:0]        size0_w, size1_w, limit_w;
  logic [NUM_SLOTS-1:0]     sel_w;
  logic [RES_W-1:0]         res_next_w;
  logic [NUM_SLOTS*RES_W-1:0] res_flat_w;
  logic                     done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  ecc_cfg_regs #(
    .NUM_SLOTS(NUM_SLOTS), .SIZE_W(SIZE_W), .CS_W(CS_W),
    .PTR_W(PTR_W), .ADDR_W(ADDR_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_core_n), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .slot_done(adv_w), .en(en_w), .ptr(ptr_w),
    .wide(wide_w), .cs(cs_w), .size0(size0_w), .size1(size1_w),
    .sel(sel_w), .clr(clr_w)
  );

  assign in_range = (ptr_w != '0) && (ptr_w <= PTR_W'(NUM_SLOTS));
  assign take_w   = en_w && in_range && xfer_valid && (xfer_cs == cs_w);

  always_comb begin
    limit_w = size0_w;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if ((ptr_w == PTR_W'(i + 1)) && sel_w[i]) limit_w = size1_w;
    end
  end

  ecc_accum #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_acc (
    .clk(clk), .rst_n(rst_core_n), .take(take_w), .wide(wide_w),
    .data(xfer_data), .limit(limit_w), .clr(clr_w),
    .close(close_w), .res_next(res_next_w)
  );

  assign adv_w = close_w;

  ecc_result_bank #(.NUM_SLOTS(NUM_SLOTS), .RES_W(RES_W), .PTR_W(PTR_W)) u_bank (
    .clk(clk), .rst_n(rst_core_n), .store(adv_w), .ptr(ptr_w),
    .wdata(res_next_w), .clr(clr_w), .res_flat(res_flat_w)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) done_q <= 1'b0;
    else             done_q <= adv_w;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(A_CTRL)) begin
      reg_rdata[B_EN]            = en_w;
      reg_rdata[B_PTR +: PTR_W]  = ptr_w;
      reg_rdata[B_WIDE]          = wide_w;
      reg_rdata[B_CS +: CS_W]    = cs_w;
    end else if (reg_addr == ADDR_W'(A_SIZE)) begin
      reg_rdata[SIZE_W-1:0]         = size0_w;
      reg_rdata[B_SIZE1 +: SIZE_W]  = size1_w;
    end else if (reg_addr == ADDR_W'(A_SEL)) begin
      reg_rdata[NUM_SLOTS-1:0] = sel_w;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (reg_addr == ADDR_W'(A_RES0 + i)) reg_rdata[RES_W-1:0] = res_flat_w[i*RES_W +: RES_W];
      end
    end
  end

  assign busy = en_w;
  assign done = done_q;
endmodule

// File: rtl/ecc_seq_chk.sv
module ecc_seq_chk #(
  parameter int unsigned NUM_SLOTS = 9,
  parameter int unsigned PTR_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [PTR_W-1:0] ptr,
  input logic             adv,
  input logic             done,
  input logic             busy,
  input logic             reg_wr
);
  localparam logic [PTR_W-1:0] LAST   = PTR_W'(NUM_SLOTS);
  localparam logic [PTR_W-1:0] FROZEN = PTR_W'(NUM_SLOTS + 1);

  // R5
  freeze_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ptr == LAST) |=> (ptr == FROZEN && !en));

  // R5
  frozen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == FROZEN) |-> !adv);

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ptr < LAST) |=> (ptr == $past(ptr) + 1'b1));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(adv) || $past(reg_wr)));

  // R9
  busy_ptr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !adv) |=> $stable(ptr));
endmodule

bind nand_ecc_seq ecc_seq_chk #(.NUM_SLOTS(NUM_SLOTS), .PTR_W(PTR_W)) u_ecc_seq_chk (
  .clk(clk), .rst_n(rst_core_n), .en(en_w), .ptr(ptr_w), .adv(adv_w),
  .done(done), .busy(busy), .reg_wr(reg_wr)
);

// File: tb/nand_ecc_seq_bench.sv
module nand_ecc_seq_bench;
  localparam int A_CTRL = 0, A_SIZE = 1, A_SEL = 2, A_RES0 = 3;
  localparam int NV = 4;
  localparam logic       V_WIDE  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [2:0] V_CS    [NV] = '{3'd2, 3'd5, 3'd0, 3'd7};
  localparam logic [8:0] V_SEL   [NV] = '{9'h100, 9'h0AA, 9'h100, 9'h1FF};
  localparam logic [9:0] V_S0    [NV] = '{10'd8, 10'd6, 10'd512, 10'd2};
  localparam logic [9:0] V_S1    [NV] = '{10'd4, 10'd2, 10'd2, 10'd10};
  localparam logic [3:0] V_START [NV] = '{4'd1, 4'd1, 4'd8, 4'd4};
  localparam logic [15:0] V_SEED [NV] = '{16'h1234, 16'hBEEF, 16'h0F0F, 16'h5A5A};

  logic        clk, rst_n, xfer_valid, reg_wr, busy, done;
  logic [2:0]  xfer_cs;
  logic [15:0] xfer_data;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  int n_chk, n_bad, done_cnt;
  logic [31:0] exp_res [1:9];

  nand_ecc_seq u_nand_ecc_seq (
    .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_cs(xfer_cs),
    .xfer_data(xfer_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) if (done) done_cnt++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    reg_addr = 4'(a);
    #1;
    v = reg_rdata;
  endtask

  task automatic xfer(input logic [2:0] c, input logic [15:0] d);
    xfer_valid = 1'b1; xfer_cs = c; xfer_data = d;
    @(negedge clk);
    xfer_valid = 1'b0;
  endtask

  function automatic logic [15:0] gen(input logic [15:0] seed, input int idx);
    logic [15:0] t;
    t = 16'(idx * 40503);
    return t ^ seed ^ 16'(idx >> 1) ^ {t[7:0], t[15:8]};
  endfunction

  function automatic logic [31:0] ctrl_word(input logic en, input logic clr, input logic [3:0] p,
                                            input logic w, input logic [2:0] c);
    return {20'd0, c, w, p, 2'b00, clr, en};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, a_w, b_w, c_w, d_w, xs, oc, u;
    logic [15:0] d;
    int n, idx;
    n_chk = 0; n_bad = 0; done_cnt = 0;
    rst_n = 1'b0; xfer_valid = 1'b0; xfer_cs = '0; xfer_data = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v); check("R1 control after reset", v, 32'h0000_0010);
    rd(A_SIZE, v); check("R1 sizes after reset", v, 32'h0002_0002);
    check("R1 busy after reset", {31'd0, busy}, 0);
    check("R1 done after reset", {31'd0, done}, 0);
    for (int s = 1; s <= 9; s++) begin
      rd(A_RES0 + s - 1, v); check($sformatf("R1 slot %0d after reset", s), v, 0);
    end

    // vector table: full runs (R2 R3 R4 R5 R6 R7 R10 R11)
    for (int vi = 0; vi < NV; vi++) begin
      wr(A_SEL, {23'd0, V_SEL[vi]});
      wr(A_SIZE, {6'd0, V_S1[vi], 6'd0, V_S0[vi]});
      wr(A_CTRL, ctrl_word(1'b0, 1'b1, V_START[vi], 1'b0, 3'd0));
      wr(A_CTRL, ctrl_word(1'b1, 1'b0, V_START[vi], V_WIDE[vi], V_CS[vi]));
      check("R6 busy after arming", {31'd0, busy}, 1);
      done_cnt = 0; idx = 0;
      for (int s = 1; s <= 9; s++) begin
        exp_res[s] = 0;
        if (s >= int'(V_START[vi])) begin
          n = V_SEL[vi][s-1] ? int'(V_S1[vi]) : int'(V_S0[vi]);
          xs = 0; oc = 0;
          for (int k = 0; k < n; k++) begin
            d = gen(V_SEED[vi], idx); idx++;
            if (k % 5 == 3) xfer(V_CS[vi] ^ 3'd1, ~d);  // R7 foreign select
            xfer(V_CS[vi], d);
            u = V_WIDE[vi] ? {16'd0, d} : {24'd0, d[7:0]};
            xs = xs ^ u; oc = oc + 32'(^u);
            if (k == n - 1) check($sformatf("R6 done after slot %0d closes", s), {31'd0, done}, 1);
          end
          exp_res[s] = {oc[15:0], xs[15:0]};
        end
      end
      rd(A_CTRL, v);
      check("R5 pointer parked", {28'd0, v[7:4]}, 10);
      check("R5 enable self-cleared", {31'd0, v[0]}, 0);
      check("R5 busy low after last slot", {31'd0, busy}, 0);
      check("R6 done pulse count", done_cnt, 32'(10 - int'(V_START[vi])));
      for (int s = 1; s <= 9; s++) begin
        rd(A_RES0 + s - 1, v);
        check($sformatf("R4 vector %0d slot %0d result", vi, s), v, exp_res[s]);
      end
    end

    // R5 transfers after freeze leave results alone
    for (int k = 0; k < 3; k++) xfer(3'd7, 16'hFFFF);
    rd(A_RES0 + 8, v); check("R5 slot 9 unchanged after freeze", v, exp_res[9]);
    rd(A_RES0 + 3, v); check("R5 slot 4 unchanged after freeze", v, exp_res[4]);

    // R8 clear while idle
    wr(A_CTRL, ctrl_word(1'b0, 1'b1, 4'd1, 1'b0, 3'd0));
    rd(A_CTRL, v); check("R8 clear bit reads zero", {31'd0, v[1]}, 0);
    rd(A_RES0 + 8, v); check("R8 slot 9 cleared", v, 0);
    rd(A_RES0 + 3, v); check("R8 slot 4 cleared", v, 0);

    // R9 writes refused while busy
    wr(A_SEL, 32'd0);
    wr(A_SIZE, {6'd0, 10'd4, 6'd0, 10'd4});
    wr(A_CTRL, ctrl_word(1'b1, 1'b0, 4'd3, 1'b1, 3'd1));
    wr(A_SIZE, {6'd0, 10'd8, 6'd0, 10'd8});
    rd(A_SIZE, v); check("R9 sizes locked while busy", v, 32'h0004_0004);
    wr(A_SEL, 32'h1FF);
    rd(A_SEL, v); check("R9 select locked while busy", v, 0);
    wr(A_CTRL, ctrl_word(1'b1, 1'b0, 4'd7, 1'b0, 3'd4));
    rd(A_CTRL, v); check("R9 control fields locked while busy", v, ctrl_word(1'b1, 1'b0, 4'd3, 1'b1, 3'd1));

    // R7 pause mid-slot, disabled transfers ignored, resume
    a_w = 32'h0000_1357; b_w = 32'h0000_2468; c_w = 32'h0000_0F01; d_w = 32'h0000_8000;
    xfer(3'd1, a_w[15:0]);
    xfer(3'd1, b_w[15:0]);
    wr(A_CTRL, ctrl_word(1'b0, 1'b0, 4'd9, 1'b0, 3'd0));
    check("R9 disable accepted while busy", {31'd0, busy}, 0);
    rd(A_CTRL, v); check("R9 pointer kept on disable", {28'd0, v[7:4]}, 3);
    for (int k = 0; k < 3; k++) xfer(3'd1, 16'hA5C3);
    wr(A_CTRL, ctrl_word(1'b1, 1'b0, 4'd3, 1'b1, 3'd1));
    xfer(3'd1, c_w[15:0]);
    check("R7 disabled transfers not counted", {31'd0, done}, 0);
    xfer(3'd1, d_w[15:0]);
    check("R3 slot closes at size0", {31'd0, done}, 1);
    rd(A_RES0 + 2, v);
    xs = a_w ^ b_w ^ c_w ^ d_w;
    oc = 32'(^a_w) + 32'(^b_w) + 32'(^c_w) + 32'(^d_w);
    check("R7 slot 3 holds enabled units only", v, {oc[15:0], xs[15:0]});
    rd(A_CTRL, v); check("R11 pointer after start at 3", {28'd0, v[7:4]}, 4);
    rd(A_RES0, v); check("R11 slot 1 untouched", v, 0);
    wr(A_CTRL, ctrl_word(1'b0, 1'b0, 4'd0, 1'b0, 3'd0));
    check("R6 busy low after disable", {31'd0, busy}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule